// File: doc/BRIEF.md
# Flash Command Mode and Status Register Front End

This block sits between software-visible registers and a flash command engine. A mode register holds the interrupt enable and a guard bit that must be set before any program or erase command may reach the engine. When a command strobe is accepted, the block pulses a start line to the engine and shows a busy bit. The engine later returns a single-cycle pass or fail pulse.

That completion clears busy and raises sticky pass or fail flags. If interrupts are enabled at that moment, it also raises a sticky interrupt flag, and this flag drives a level interrupt output. Reading the status register clears the sticky flags. A flag set by a completion in the same cycle as the read stays set. Program or erase commands issued while the guard bit is clear never start the engine. They are reported as failures. The flash array and the command sequencing inside the engine are outside this block.

Top module: `flash_cmd_status`

## Requirements
- R1: After reset the status word reads 0x0020 (bit 5 is a constant 1), the mode word reads 0x0000, and `irq` and `engStart` are 0.
- R2: A mode write stores bits 7:3 of the written data. Bits 15:8 and 2:0 always read back as 0. Bit 3 is the program/erase guard and bit 4 is the interrupt enable.
- R3: A command strobe taken while idle and not blocked gives a one-cycle `engStart` pulse in the following cycle. Status bit 2 (busy) reads 1 from that same cycle on.
- R4: An `engPass` or `engFail` pulse while busy clears busy in the next cycle. Such pulses while idle change nothing.
- R5: A pass completion sets status bit 0 and a fail completion sets status bit 1. Both bits stay set until the status register is read.
- R6: Command kinds use codes 0 read, 1 program, 2 erase and 3 verify. A program or erase strobe while mode bit 3 is 0 produces no `engStart` and leaves busy at 0. It sets status bit 1 in the next cycle. Read and verify strobes are never blocked.
- R7: Status bit 3 is set at a completion only when mode bit 4 is 1 in that cycle.
- R8: A cycle with `statusRdEn` high clears status bits 0, 1 and 3 at its clock edge. Busy and bit 5 are not affected.
- R9: When a completion coincides with a status read, the flag set by that completion remains set and the other sticky flags are cleared.
- R10: `irq` is high exactly while status bit 3 is set.
- R11: A command strobe while busy is ignored. No `engStart` is produced and busy ends only with the pending completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeWrEn | input | 1 | Mode register write strobe |
| modeWrData | input | 16 | Data for a mode register write |
| modeRdData | output | 16 | Current mode register value |
| statusRdEn | input | 1 | Status read strobe, clears sticky flags |
| statusRdData | output | 16 | Current status word |
| cmdValid | input | 1 | Command strobe |
| cmdKind | input | 2 | Command kind: 0 read, 1 program, 2 erase, 3 verify |
| engStart | output | 1 | One-cycle start pulse to the engine |
| engPass | input | 1 | Engine completion, successful |
| engFail | input | 1 | Engine completion, unsuccessful |
| irq | output | 1 | Level interrupt, follows status bit 3 |

## Verification
The assertions assume that the engine raises `engPass` and `engFail` only as single-cycle pulses, never both in one cycle, and only after it has been started. Stray pulses while idle are tolerated by the design and are exercised deliberately. The stimulus keeps to this by driving completions from a fixed-latency stub inside command tasks. The only extra pass pulse is injected while the block is idle. A behavioural model in the bench predicts every output, and the outputs are compared with it on each clock. Directed checks cover blocked commands, strobes while busy, and a status read that lands on the completion cycle.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int DATA_W = 16;
  localparam int KIND_W = 2;

  // Mode register fields
  localparam int MODE_GUARD_BIT = 3;
  localparam int MODE_IE_BIT    = 4;
  localparam int MODE_LO_KEEP   = 3;
  localparam int MODE_HI_KEEP   = 7;

  // Status register fields
  localparam int ST_PASS_BIT  = 0;
  localparam int ST_FAIL_BIT  = 1;
  localparam int ST_BUSY_BIT  = 2;
  localparam int ST_IRQ_BIT   = 3;
  localparam int ST_CONST_BIT = 5;
  localparam int N_STICKY     = 3;

  typedef enum logic [KIND_W-1:0] {
    CMD_READ   = 2'd0,
    CMD_PROG   = 2'd1,
    CMD_ERASE  = 2'd2,
    CMD_VERIFY = 2'd3
  } cmdKind_e;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} engState_e;

  typedef struct packed {
    logic setIrq;
    logic setFail;
    logic setPass;
    logic clrSticky;
  } ctrlStrobe_t;
endpackage

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [KIND_W-1:0] cmdKind,
  input  logic              engPass,
  input  logic              engFail,
  input  logic              statusRdEn,
  input  logic              guardOpen,
  input  logic              irqEnable,
  output logic              busy,
  output logic              engStart,
  output ctrlStrobe_t       strobe
);
  engState_e state;
  logic done, gated, accept, reject;

  always_comb begin
    done   = (state == ST_RUN) && (engPass || engFail);
    gated  = ((cmdKind == CMD_PROG) || (cmdKind == CMD_ERASE)) && !guardOpen;
    accept = cmdValid && (state == ST_IDLE) && !gated;
    reject = cmdValid && (state == ST_IDLE) && gated;
    strobe.setPass   = done && engPass;
    strobe.setFail   = (done && engFail) || reject;
    strobe.setIrq    = done && irqEnable;
    strobe.clrSticky = statusRdEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      engStart <= 1'b0;
    end else begin
      engStart <= accept;
      if (accept)    state <= ST_RUN;
      else if (done) state <= ST_IDLE;
    end
  end

  assign busy = (state == ST_RUN);

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> (busy && !$past(busy))); // R3
  AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdValid) |=> !engStart); // R11
  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (engPass || engFail)) |=> !busy); // R4
  AST_GUARD_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdValid && !guardOpen && (cmdKind == CMD_PROG || cmdKind == CMD_ERASE))
      |=> (!busy && !engStart)); // R6
endmodule

// File: rtl/fcs_dp.sv
module fcs_dp
  import fcs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWrEn,
  input  logic [DATA_W-1:0] modeWrData,
  input  ctrlStrobe_t       strobe,
  input  logic              busy,
  output logic [DATA_W-1:0] modeRdData,
  output logic [DATA_W-1:0] statusRdData,
  output logic              guardOpen,
  output logic              irqEnable,
  output logic              irqFlag
);
  localparam logic [DATA_W-1:0] MODE_MASK =
    DATA_W'(((1 << (MODE_HI_KEEP + 1)) - 1) & ~((1 << MODE_LO_KEEP) - 1));

  logic [DATA_W-1:0]   modeQ;
  logic [N_STICKY-1:0] stickyQ;
  logic [N_STICKY-1:0] setVec;

  assign setVec = {strobe.setIrq, strobe.setFail, strobe.setPass};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         modeQ <= '0;
    else if (modeWrEn) modeQ <= modeWrData & MODE_MASK;
  end

  for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 stickyQ[i] <= 1'b0;
      else if (setVec[i])        stickyQ[i] <= 1'b1;
      else if (strobe.clrSticky) stickyQ[i] <= 1'b0;
    end
  end

  always_comb begin
    statusRdData               = '0;
    statusRdData[ST_PASS_BIT]  = stickyQ[0];
    statusRdData[ST_FAIL_BIT]  = stickyQ[1];
    statusRdData[ST_BUSY_BIT]  = busy;
    statusRdData[ST_IRQ_BIT]   = stickyQ[2];
    statusRdData[ST_CONST_BIT] = 1'b1;
  end

  assign modeRdData = modeQ;
  assign guardOpen  = modeQ[MODE_GUARD_BIT];
  assign irqEnable  = modeQ[MODE_IE_BIT];
  assign irqFlag    = stickyQ[2];

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stickyQ[2]) |-> $past(modeQ[MODE_IE_BIT])); // R7
  AST_READ_CLEARS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrSticky && !strobe.setPass) |=> !stickyQ[0]); // R8
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrSticky && strobe.setFail) |=> stickyQ[1]); // R9
endmodule

// File: rtl/flash_cmd_status.sv
module flash_cmd_status
  import fcs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWrEn,
  input  logic [DATA_W-1:0] modeWrData,
  output logic [DATA_W-1:0] modeRdData,
  input  logic              statusRdEn,
  output logic [DATA_W-1:0] statusRdData,
  input  logic              cmdValid,
  input  logic [KIND_W-1:0] cmdKind,
  output logic              engStart,
  input  logic              engPass,
  input  logic              engFail,
  output logic              irq
);
  ctrlStrobe_t strobe;
  logic busy, guardOpen, irqEnable, irqFlag;

  fcs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .engPass(engPass), .engFail(engFail), .statusRdEn(statusRdEn),
    .guardOpen(guardOpen), .irqEnable(irqEnable),
    .busy(busy), .engStart(engStart), .strobe(strobe)
  );

  fcs_dp u_dp (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .strobe(strobe), .busy(busy), .modeRdData(modeRdData),
    .statusRdData(statusRdData), .guardOpen(guardOpen),
    .irqEnable(irqEnable), .irqFlag(irqFlag)
  );

  assign irq = irqFlag; // R10
endmodule

// File: tb/flash_cmd_status_bench.sv
module flash_cmd_status_bench;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeWrEn = 1'b0;
  logic [15:0] modeWrData = '0;
  logic [15:0] modeRdData;
  logic statusRdEn = 1'b0;
  logic [15:0] statusRdData;
  logic cmdValid = 1'b0;
  logic [1:0] cmdKind = '0;
  logic engStart;
  logic engPass = 1'b0;
  logic engFail = 1'b0;
  logic irq;

  int errCount = 0;
  int chkCount = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  flash_cmd_status u_flash_cmd_status (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .modeRdData(modeRdData), .statusRdEn(statusRdEn), .statusRdData(statusRdData),
    .cmdValid(cmdValid), .cmdKind(cmdKind), .engStart(engStart),
    .engPass(engPass), .engFail(engFail), .irq(irq)
  );

  // Behavioural reference model
  bit mBusy, mPass, mFail, mIrq, mStart;
  bit [15:0] mMode;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy = 0; mPass = 0; mFail = 0; mIrq = 0; mStart = 0; mMode = 16'h0;
    end else begin
      bit sp, sf, si, nb, ns;
      sp = 0; sf = 0; si = 0; nb = mBusy; ns = 0;
      if (mBusy && (engPass || engFail)) begin
        nb = 0; sp = engPass; sf = engFail; si = mMode[4];
      end else if (!mBusy && cmdValid) begin
        if ((cmdKind == 2'd1 || cmdKind == 2'd2) && !mMode[3]) sf = 1;
        else begin nb = 1; ns = 1; end
      end
      if (statusRdEn) begin mPass = 0; mFail = 0; mIrq = 0; end
      if (sp) mPass = 1;
      if (sf) mFail = 1;
      if (si) mIrq = 1;
      mBusy = nb; mStart = ns;
      if (modeWrEn) mMode = modeWrData & 16'h00F8;
    end
  end

  function automatic logic [15:0] modelStatus();
    return {10'h0, 1'b1, 1'b0, mIrq, mBusy, mFail, mPass};
  endfunction

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    chkCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s %s actual=0x%04h expected=0x%04h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock
  always @(negedge clk) begin
    if (rstN) begin
      check(curReq, "status", statusRdData, modelStatus());
      check(curReq, "mode", modeRdData, mMode);
      check("R10", "irq", {15'h0, irq}, {15'h0, mIrq});
      check(curReq, "engStart", {15'h0, engStart}, {15'h0, mStart});
    end
  end

  task automatic writeMode(logic [15:0] v);
    @(negedge clk); modeWrEn = 1; modeWrData = v;
    @(negedge clk); modeWrEn = 0;
  endtask

  task automatic readStatus();
    @(negedge clk); statusRdEn = 1;
    @(negedge clk); statusRdEn = 0;
  endtask

  // Issue a command; the stub completes it LAT cycles after the start pulse
  task automatic runCmd(logic [1:0] kind, bit failRes, bit readAtDone, bit pokeWhileBusy);
    @(negedge clk); cmdValid = 1; cmdKind = kind;
    @(negedge clk); cmdValid = 0;
    check("R3", "start pulse", {15'h0, engStart}, 16'h1);
    check("R3", "busy bit", {15'h0, statusRdData[2]}, 16'h1);
    if (pokeWhileBusy) begin
      cmdValid = 1; cmdKind = 2'd0;
      @(negedge clk); cmdValid = 0;
      check("R11", "no start while busy", {15'h0, engStart}, 16'h0);
      check("R11", "still busy", {15'h0, statusRdData[2]}, 16'h1);
      repeat (LAT - 2) @(negedge clk);
    end else begin
      repeat (LAT - 1) @(negedge clk);
    end
    engPass = !failRes; engFail = failRes; statusRdEn = readAtDone;
    @(negedge clk); engPass = 0; engFail = 0; statusRdEn = 0;
    check("R4", "busy cleared", {15'h0, statusRdData[2]}, 16'h0);
  endtask

  initial begin
    #2_000_000;
    errCount++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errCount, chkCount + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset status", statusRdData, 16'h0020);
    check("R1", "reset mode", modeRdData, 16'h0000);
    check("R1", "reset irq", {15'h0, irq}, 16'h0);
    check("R1", "reset start", {15'h0, engStart}, 16'h0);
    rstN = 1;

    curReq = "R2";
    writeMode(16'hFFFF);
    check("R2", "reserved mode bits", modeRdData, 16'h00F8);
    writeMode(16'h0008);

    curReq = "R5";
    runCmd(2'd1, 1'b0, 1'b0, 1'b0);
    check("R5", "pass flag", statusRdData, 16'h0021);
    check("R7", "no irq flag when disabled", {15'h0, statusRdData[3]}, 16'h0);

    curReq = "R8";
    readStatus();
    check("R8", "flags cleared", statusRdData, 16'h0020);

    curReq = "R7";
    writeMode(16'h0018);
    runCmd(2'd2, 1'b1, 1'b0, 1'b0);
    check("R7", "fail plus irq flag", statusRdData, 16'h002A);
    check("R10", "irq level", {15'h0, irq}, 16'h1);
    repeat (3) @(negedge clk);
    check("R5", "flags sticky", statusRdData, 16'h002A);
    readStatus();
    check("R8", "cleared after read", statusRdData, 16'h0020);
    check("R10", "irq dropped", {15'h0, irq}, 16'h0);

    curReq = "R6";
    writeMode(16'h0010);
    @(negedge clk); cmdValid = 1; cmdKind = 2'd2;
    @(negedge clk); cmdValid = 0;
    check("R6", "erase blocked no start", {15'h0, engStart}, 16'h0);
    check("R6", "erase blocked fail", statusRdData, 16'h0022);
    readStatus();
    @(negedge clk); cmdValid = 1; cmdKind = 2'd1;
    @(negedge clk); cmdValid = 0;
    check("R6", "program blocked", statusRdData, 16'h0022);
    readStatus();
    runCmd(2'd3, 1'b0, 1'b0, 1'b0);
    check("R6", "verify not gated", statusRdData, 16'h0029);

    curReq = "R11";
    readStatus();
    writeMode(16'h0008);
    runCmd(2'd0, 1'b0, 1'b0, 1'b1);
    check("R11", "single completion", statusRdData, 16'h0021);
    readStatus();

    curReq = "R4";
    @(negedge clk); engPass = 1;
    @(negedge clk); engPass = 0;
    check("R4", "stray pass ignored", statusRdData, 16'h0020);

    curReq = "R9";
    writeMode(16'h0018);
    runCmd(2'd1, 1'b1, 1'b0, 1'b0);
    writeMode(16'h0008);
    runCmd(2'd1, 1'b0, 1'b1, 1'b0);
    check("R9", "pass kept, old flags cleared", statusRdData, 16'h0021);
    check("R10", "irq low", {15'h0, irq}, 16'h0);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end
endmodule